// File: doc/BRIEF.md
# Keyed Configuration Bank with Chip-Select Window Decoder

This block is a small indexed configuration bank that a host reaches through three byte-wide I/O ports: a key port, an index port and a data port. The bank stays locked until the host writes the unlock byte 89h into the key port. While it is unlocked, the index port chooses a configuration register and the data port reads or writes it.

Two registers of the bank hold an 11-bit base address and a 2-bit window mode for one general-purpose chip-select. The decoder compares the host address against the base. Depending on the mode it ignores 0, 1, 2 or 3 low address bits. It drives a select output in the same cycle whenever an I/O read or write strobe is active and the address falls inside the window.

Top module: `cfg_keyed_decoder`

## Requirements
- R1: After reset the key register reads 00h, the base address and the mode are 0, a data-port read returns FFh, and the select output is low while no strobe is active.
- R2: A write of 89h to the key port unlocks the bank. A write of any other value locks it. The key port reads back the last value written to it.
- R3: While the bank is locked, data-port writes leave the base and the mode unchanged, and data-port reads return FFh.
- R4: The index port stores the byte written to it and reads it back. That byte selects the register that the data port reaches. A read at an address that is none of the three ports returns 00h.
- R5: While the bank is unlocked, index 10h reads and writes base address bits 7..0 through the data port.
- R6: Index 11h maps base address bits 10..8 to data bits 2..0 and the window mode to data bits 7..6. Data bits 5..3 are written without effect and read as 0.
- R7: Every index other than 10h and 11h, including 0Eh and 0Fh, reads 00h, and writes to it change neither the base nor the mode.
- R8: Mode 00 compares address bits 10..0 with the base (1-byte window). Mode 01 compares bits 10..1 (2 bytes), mode 10 compares bits 10..2 (4 bytes) and mode 11 compares bits 10..3 (8 bytes).
- R9: The select output is combinational on the address. It is high only while io_rd or io_wr is high.
- R10: When the host address is wider than 11 bits, the select output requires every address bit above bit 10 to be zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register bank |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_rd | input | 1 | Host I/O read strobe |
| io_wr | input | 1 | Host I/O write strobe, sampled on the rising clock edge |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data for the key, index and data ports |
| gp_sel | output | 1 | Chip-select for the programmed address window |

## Verification
The bench builds the block with a 16-bit host address, keeping the three default port addresses. This brings the upper-bit qualification variant of the decoder into play, so that aliases of the window at higher addresses must be rejected. Random traffic moves the base and the mode. Probes land just inside and just outside each window size, and some of them carry upper address bits.

// File: rtl/cfg_kd_pkg.sv
package cfg_kd_pkg;

   // Chip-select base width and host register width.
   localparam int BASE_W = 11;
   localparam int REG_W  = 8;
   localparam int HI_W   = BASE_W - REG_W;
   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      WIN_1B = 2'b00,
      WIN_2B = 2'b01,
      WIN_4B = 2'b10,
      WIN_8B = 2'b11
   } win_mode_e;

   typedef struct packed {
      logic key;
      logic idx;
      logic data;
   } port_hit_t;

endpackage

// File: rtl/cfg_kd_portdec.sv
module cfg_kd_portdec
   import cfg_kd_pkg::*;
#(
   parameter int                ADDR_W    = 11,
   parameter logic [ADDR_W-1:0] KEY_PORT  = 'h0E0,
   parameter logic [ADDR_W-1:0] IDX_PORT  = 'h0E1,
   parameter logic [ADDR_W-1:0] DATA_PORT = 'h0E2
) (
   input  logic [ADDR_W-1:0] addr,
   output port_hit_t         hit
);

   if (KEY_PORT == IDX_PORT || KEY_PORT == DATA_PORT || IDX_PORT == DATA_PORT) begin : g_bad_ports
      $error("cfg_kd_portdec: the three host ports need distinct addresses");
   end

   assign hit.key  = (addr == KEY_PORT);
   assign hit.idx  = (addr == IDX_PORT);
   assign hit.data = (addr == DATA_PORT);

endmodule

// File: rtl/cfg_kd_regbank.sv
module cfg_kd_regbank
   import cfg_kd_pkg::*;
#(
   parameter logic [REG_W-1:0] KEY_VALUE   = 8'h89,
   parameter logic [REG_W-1:0] IDX_LO      = 8'h10,
   parameter logic [REG_W-1:0] IDX_HI      = 8'h11,
   parameter logic [REG_W-1:0] CLOSED_READ = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  port_hit_t         hit,
   input  logic              io_wr,
   input  logic [REG_W-1:0]  io_wdata,
   output logic [REG_W-1:0]  io_rdata,
   output logic              key_open,
   output logic [REG_W-1:0]  idx_q,
   output logic [BASE_W-1:0] base_q,
   output win_mode_e         mode_q
);

   localparam int PAD_W = REG_W - MODE_W - HI_W;

   if (IDX_LO == IDX_HI) begin : g_bad_idx
      $error("cfg_kd_regbank: the two base indexes must differ");
   end
   if (PAD_W < 0) begin : g_bad_pack
      $error("cfg_kd_regbank: high base bits and mode do not fit one register");
   end

   logic [REG_W-1:0] key_q;
   logic [REG_W-1:0] data_view;

   assign key_open = (key_q == KEY_VALUE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         key_q  <= '0;
         idx_q  <= '0;
         base_q <= '0;
         mode_q <= WIN_1B;
      end else if (io_wr) begin
         if (hit.key) begin
            key_q <= io_wdata;
         end
         if (hit.idx) begin
            idx_q <= io_wdata;
         end
         if (hit.data && key_open) begin
            if (idx_q == IDX_LO) begin
               base_q[REG_W-1:0] <= io_wdata;
            end else if (idx_q == IDX_HI) begin
               base_q[BASE_W-1:REG_W] <= io_wdata[HI_W-1:0];
               mode_q                 <= win_mode_e'(io_wdata[REG_W-1 -: MODE_W]);
            end
         end
      end
   end

   always_comb begin
      if (idx_q == IDX_LO) begin
         data_view = base_q[REG_W-1:0];
      end else if (idx_q == IDX_HI) begin
         data_view = {mode_q, {PAD_W{1'b0}}, base_q[BASE_W-1:REG_W]};
      end else begin
         data_view = '0;
      end
   end

   always_comb begin
      if (hit.key) begin
         io_rdata = key_q;
      end else if (hit.idx) begin
         io_rdata = idx_q;
      end else if (hit.data) begin
         io_rdata = key_open ? data_view : CLOSED_READ;
      end else begin
         io_rdata = '0;
      end
   end

endmodule

// File: rtl/cfg_kd_windec.sv
module cfg_kd_windec
   import cfg_kd_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BASE_W-1:0] base,
   input  win_mode_e         mode,
   input  logic              strobe,
   output logic              sel
);

   localparam int MASK_MAX = (1 << MODE_W) - 1;

   if (ADDR_W < BASE_W) begin : g_bad_width
      $error("cfg_kd_windec: host address narrower than the base address");
   end

   logic [BASE_W-1:0] bit_ok;
   logic              upper_ok;

   for (genvar i = 0; i < BASE_W; i++) begin : g_bit
      if (i < MASK_MAX) begin : g_maskable
         // A low bit drops out of the compare once the mode reaches past it.
         assign bit_ok[i] = (addr[i] == base[i]) || (mode > MODE_W'(i));
      end else begin : g_fixed
         assign bit_ok[i] = (addr[i] == base[i]);
      end
   end

   if (ADDR_W > BASE_W) begin : g_upper
      assign upper_ok = ~|addr[ADDR_W-1:BASE_W];
   end else begin : g_no_upper
      assign upper_ok = 1'b1;
   end

   assign sel = strobe && upper_ok && (&bit_ok);

endmodule

// File: rtl/cfg_keyed_decoder.sv
module cfg_keyed_decoder
   import cfg_kd_pkg::*;
#(
   parameter int                ADDR_W    = 11,
   parameter logic [ADDR_W-1:0] KEY_PORT  = 'h0E0,
   parameter logic [ADDR_W-1:0] IDX_PORT  = 'h0E1,
   parameter logic [ADDR_W-1:0] DATA_PORT = 'h0E2,
   parameter logic [7:0]        KEY_VALUE = 8'h89,
   parameter logic [7:0]        IDX_LO    = 8'h10,
   parameter logic [7:0]        IDX_HI    = 8'h11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic              gp_sel
);

   port_hit_t         hit;
   logic              key_open;
   logic [REG_W-1:0]  idx_q;
   logic [BASE_W-1:0] base_q;
   win_mode_e         mode_q;

   cfg_kd_portdec #(
      .ADDR_W   (ADDR_W),
      .KEY_PORT (KEY_PORT),
      .IDX_PORT (IDX_PORT),
      .DATA_PORT(DATA_PORT)
   ) u_portdec (
      .addr(io_addr),
      .hit (hit)
   );

   cfg_kd_regbank #(
      .KEY_VALUE  (KEY_VALUE),
      .IDX_LO     (IDX_LO),
      .IDX_HI     (IDX_HI),
      .CLOSED_READ(8'hFF)
   ) u_regbank (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .io_wr   (io_wr),
      .io_wdata(io_wdata),
      .io_rdata(io_rdata),
      .key_open(key_open),
      .idx_q   (idx_q),
      .base_q  (base_q),
      .mode_q  (mode_q)
   );

   cfg_kd_windec #(
      .ADDR_W(ADDR_W)
   ) u_windec (
      .addr  (io_addr),
      .base  (base_q),
      .mode  (mode_q),
      .strobe(io_rd || io_wr),
      .sel   (gp_sel)
   );

endmodule

// File: rtl/cfg_kd_chk.sv
module cfg_kd_chk
   import cfg_kd_pkg::*;
#(
   parameter int                ADDR_W    = 11,
   parameter logic [ADDR_W-1:0] KEY_PORT  = 'h0E0,
   parameter logic [ADDR_W-1:0] DATA_PORT = 'h0E2,
   parameter logic [7:0]        KEY_VALUE = 8'h89,
   parameter logic [7:0]        IDX_LO    = 8'h10,
   parameter logic [7:0]        IDX_HI    = 8'h11
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_rd,
   input logic              io_wr,
   input logic [7:0]        io_wdata,
   input logic [7:0]        io_rdata,
   input logic              gp_sel,
   input logic              key_open,
   input logic [7:0]        idx_q,
   input logic [BASE_W-1:0] base_q,
   input win_mode_e         mode_q
);

   AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> (!key_open && base_q == '0 && mode_q == WIN_1B)); // R1

   AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == KEY_PORT && io_wdata == KEY_VALUE) |=> key_open); // R2

   AST_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == KEY_PORT && io_wdata != KEY_VALUE) |=> !key_open); // R2

   AST_CLOSED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!key_open && io_addr == DATA_PORT) |-> io_rdata == 8'hFF); // R3

   AST_CLOSED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!key_open && io_wr && io_addr == DATA_PORT) |=> ($stable(base_q) && $stable(mode_q))); // R3

   AST_RSVD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      (key_open && io_wr && io_addr == DATA_PORT && idx_q != IDX_LO && idx_q != IDX_HI)
      |=> ($stable(base_q) && $stable(mode_q))); // R7

   AST_EXACT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (gp_sel && mode_q == WIN_1B) |-> io_addr[BASE_W-1:0] == base_q); // R8

   AST_SEL_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      gp_sel |-> (io_rd || io_wr)); // R9

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      gp_sel |-> (io_addr >> BASE_W) == '0); // R10

endmodule

bind cfg_keyed_decoder cfg_kd_chk #(
   .ADDR_W   (ADDR_W),
   .KEY_PORT (KEY_PORT),
   .DATA_PORT(DATA_PORT),
   .KEY_VALUE(KEY_VALUE),
   .IDX_LO   (IDX_LO),
   .IDX_HI   (IDX_HI)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .io_addr (io_addr),
   .io_rd   (io_rd),
   .io_wr   (io_wr),
   .io_wdata(io_wdata),
   .io_rdata(io_rdata),
   .gp_sel  (gp_sel),
   .key_open(key_open),
   .idx_q   (idx_q),
   .base_q  (base_q),
   .mode_q  (mode_q)
);

// File: tb/cfg_keyed_decoder_tb_top.sv
`timescale 1ns/1ps
module cfg_keyed_decoder_tb_top;

   localparam int         AW     = 16;
   localparam logic [15:0] P_KEY  = 16'h00E0;
   localparam logic [15:0] P_IDX  = 16'h00E1;
   localparam logic [15:0] P_DATA = 16'h00E2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] io_addr = '0;
   logic          io_rd = 1'b0;
   logic          io_wr = 1'b0;
   logic [7:0]    io_wdata = '0;
   logic [7:0]    io_rdata;
   logic          gp_sel;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // Bench model of the programmed state.
   logic [7:0]  m_key  = '0;
   logic [7:0]  m_idx  = '0;
   logic [10:0] m_base = '0;
   logic [1:0]  m_mode = '0;

   always #2.5 clk = ~clk;

   cfg_keyed_decoder #(
      .ADDR_W   (AW),
      .KEY_PORT (P_KEY),
      .IDX_PORT (P_IDX),
      .DATA_PORT(P_DATA)
   ) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_addr (io_addr),
      .io_rd   (io_rd),
      .io_wr   (io_wr),
      .io_wdata(io_wdata),
      .io_rdata(io_rdata),
      .gp_sel  (gp_sel)
   );

   function automatic logic [7:0] exp_rdata(logic [AW-1:0] a);
      if (a == P_KEY) return m_key;
      if (a == P_IDX) return m_idx;
      if (a == P_DATA) begin
         if (m_key != 8'h89) return 8'hFF;
         if (m_idx == 8'h10) return m_base[7:0];
         if (m_idx == 8'h11) return {m_mode, 3'b000, m_base[10:8]};
         return 8'h00;
      end
      return 8'h00;
   endfunction

   function automatic logic exp_sel(logic [AW-1:0] a, logic strobe);
      logic [10:0] msk;
      msk = 11'h7FF << m_mode;
      return strobe && (a[AW-1:11] == '0) && ((a[10:0] & msk) == (m_base & msk));
   endfunction

   function automatic string rd_tag(logic [AW-1:0] a);
      if (a == P_KEY) return "R2";
      if (a == P_DATA) begin
         if (m_key != 8'h89) return "R3";
         if (m_idx == 8'h10) return "R5";
         if (m_idx == 8'h11) return "R6";
         return "R7";
      end
      return "R4";
   endfunction

   function automatic string sel_tag(logic [AW-1:0] a);
      if (a[AW-1:11] != '0) return "R10";
      return "R8";
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_write(logic [AW-1:0] a, logic [7:0] d);
      if (a == P_KEY) m_key = d;
      else if (a == P_IDX) m_idx = d;
      else if (a == P_DATA && m_key == 8'h89) begin
         if (m_idx == 8'h10) m_base[7:0] = d;
         else if (m_idx == 8'h11) begin
            m_base[10:8] = d[2:0];
            m_mode = d[7:6];
         end
      end
   endtask

   task automatic io_write(logic [AW-1:0] a, logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      #1;
      chk(sel_tag(a), {7'd0, gp_sel}, {7'd0, exp_sel(a, 1'b1)});
      @(posedge clk);
      #1;
      io_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic io_read(logic [AW-1:0] a, string tag = "");
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1;
      chk((tag != "") ? tag : rd_tag(a), io_rdata, exp_rdata(a));
      chk((tag != "") ? tag : sel_tag(a), {7'd0, gp_sel}, {7'd0, exp_sel(a, 1'b1)});
      @(posedge clk);
      #1;
      io_rd = 1'b0;
   endtask

   task automatic probe_idle(logic [AW-1:0] a, string tag);
      @(negedge clk);
      io_addr = a; io_rd = 1'b0; io_wr = 1'b0;
      #1;
      chk(tag, {7'd0, gp_sel}, 8'h00);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int unsigned seed_val;
      seed_val = $urandom(32'd24680);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      io_read(P_KEY, "R1");
      io_read(P_DATA, "R1");
      probe_idle(16'h0000, "R1");

      // R2, R4, R5, R6: unlock and program the window
      io_write(P_KEY, 8'h89);
      io_read(P_KEY, "R2");
      io_write(P_IDX, 8'h10);
      io_read(P_IDX, "R4");
      io_write(P_DATA, 8'hA5);
      io_read(P_DATA, "R5");
      io_write(P_IDX, 8'h11);
      io_write(P_DATA, 8'h3A);           // reserved bits set, mode 00
      io_read(P_DATA, "R6");
      io_read(16'h0123, "R4");

      // R8: each window size at its edges (base 2A5h)
      io_read(16'h02A5, "R8");
      io_read(16'h02A4, "R8");
      io_write(P_DATA, 8'h42);
      io_read(16'h02A4, "R8");
      io_read(16'h02A6, "R8");
      io_write(P_DATA, 8'h82);
      io_read(16'h02A7, "R8");
      io_read(16'h02A8, "R8");
      io_write(P_DATA, 8'hC2);
      io_read(16'h02A0, "R8");
      io_read(16'h029F, "R8");

      // R10: upper address bits block the match
      io_read(16'h82A5, "R10");
      io_read(16'h08A3, "R10");

      // R9: no strobe, no select
      probe_idle(16'h02A3, "R9");

      // R3: locked bank ignores data writes and reads FFh
      io_write(P_KEY, 8'h88);
      io_read(P_DATA, "R3");
      io_write(P_DATA, 8'h00);
      io_write(P_KEY, 8'h89);
      io_read(P_DATA, "R3");
      io_read(16'h02A2, "R3");

      // R7: reserved indexes
      io_write(P_IDX, 8'h0E);
      io_write(P_DATA, 8'h55);
      io_read(P_DATA, "R7");
      io_write(P_IDX, 8'h0F);
      io_write(P_DATA, 8'hFF);
      io_read(P_DATA, "R7");
      io_write(P_IDX, 8'h10);
      io_read(P_DATA, "R7");
      io_write(P_IDX, 8'h11);
      io_read(P_DATA, "R7");

      // Random traffic
      for (int n = 0; n < 4000; n++) begin
         int unsigned op;
         logic [AW-1:0] a;
         logic [7:0] d;
         op = $urandom_range(0, 9);
         d  = 8'($urandom);
         case (op)
            0: io_write(P_KEY, ($urandom_range(0, 3) == 0) ? d : 8'h89);
            1: begin
               case ($urandom_range(0, 4))
                  0: io_write(P_IDX, 8'h10);
                  1: io_write(P_IDX, 8'h11);
                  2: io_write(P_IDX, 8'h0E);
                  3: io_write(P_IDX, 8'h0F);
                  default: io_write(P_IDX, d);
               endcase
            end
            2, 3: io_write(P_DATA, d);
            4: begin
               case ($urandom_range(0, 2))
                  0: io_read(P_KEY);
                  1: io_read(P_IDX);
                  default: io_read(P_DATA);
               endcase
            end
            9: begin
               a = {5'd0, m_base};
               probe_idle(a, "R9");
            end
            default: begin
               a = '0;
               a[10:0] = m_base + 11'($urandom_range(0, 9)) - 11'd1;
               if ($urandom_range(0, 7) == 0) a[AW-1:11] = 5'($urandom_range(1, 31));
               if ($urandom_range(0, 1) == 0) io_read(a);
               else io_write(a, d);
            end
         endcase
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule